// File: doc/BRIEF.md
# Streaming NAND Hamming ECC generator

This block builds the 22-bit Hamming check code of NAND page data while the bytes flow through a flash controller. Every accepted byte is given an 11-bit bit address per data bit (eight byte-index bits above three bit-position bits). Two 11-bit parity words are kept for each 256-byte chunk: one collects the data bits whose address has a given bit set, the other collects those whose address has that bit clear. The two words are complements in coverage, so a single flipped data bit changes one bit of every set/clear pair. The flipped bit's location can then be read straight from the difference.

The controller pulses the clear strobe before every page transfer and then streams the bytes with a valid qualifier. In 256-byte mode one register pair holds the code. In 512-byte mode a second pair takes bytes 256 to 511, and each half's code is produced separately. The packed codes are registered outputs and can be read as soon as the last byte has been accepted.

Top module: `nand_ecc_gen`

## Requirements
- R1: While `rst` is high, both codes are cleared to zero and the byte position returns to 0 in the first chunk.
- R2: For address bit k (0..10), `code*_o[k]` is the XOR of all data bits in the chunk whose bit address (byte index within the chunk times 8 plus bit position, bit 0 = LSB) has bit k set. `code*_o[11+k]` is the XOR of all data bits whose bit address has bit k clear.
- R3: A chunk of zero bytes with a single one at byte B, bit b yields a low word `code[10:0]` equal to {B,b} and a high word `code[21:11]` equal to its bitwise inverse.
- R4: A chunk of all 0xFF bytes yields an all-zero code.
- R5: Only cycles with `valid_i` high advance the byte position or change a code. Idle cycles hold both codes, whatever is on `byte_i`.
- R6: A `clr_i` pulse zeroes both codes and the byte position at the next edge. A byte presented in the same cycle as `clr_i` is discarded.
- R7: With `mode512_i` high, bytes 0..255 go to `code0_o` and bytes 256..511 go to `code1_o`, with byte indices taken relative to 256. After byte 511 the position wraps to byte 0 of `code0_o`.
- R8: With `mode512_i` low, every byte goes to `code0_o`, the position wraps after byte 255 and `code1_o` does not change.
- R9: A byte accepted at a clock edge is reflected in the code outputs right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Per-page clear strobe for codes and byte position |
| mode512_i | input | 1 | 1: two 256-byte chunks per transfer; 0: single chunk |
| valid_i | input | 1 | Qualifies `byte_i` in this cycle |
| byte_i | input | DATA_W (8) | Data byte |
| code0_o | output | 2*AW (22) | Code of the first chunk: {clear word, set word} |
| code1_o | output | 2*AW (22) | Code of the second chunk in 512-byte mode |

## Verification
A sweep places a single one bit in every byte position of an otherwise zero chunk. The exact {B,b} low word and its inverse tell apart errors in any address bit, in the bit-position decode and in word order. An all-0xFF chunk confirms the erased-page zero code. A structured non-repeating 512-byte pattern is compared against an arithmetic XOR-of-addresses model, which separates the two halves and the relative addressing of the upper chunk. The same data sent with idle gaps carrying junk bytes, sent past the 512 and 256 wrap points, and sent with a clear coinciding with a valid byte shows whether the byte position advances only on accepted bytes.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  // Mask of bit positions j (within a data word) whose index has bit k set.
  function automatic logic [31:0] idx_mask(input int k);
    logic [31:0] m;
    for (int j = 0; j < 32; j++) begin
      m[j] = ((j >> k) & 1) != 0;
    end
    return m;
  endfunction

endpackage

// File: rtl/nand_ecc_contrib.sv
// Per-byte contribution to the set and clear parity words.
module nand_ecc_contrib #(
  parameter int DATA_W  = 8,
  parameter int BADDR_W = 8,
  localparam int BIDX_W = $clog2(DATA_W),
  localparam int AW     = BADDR_W + BIDX_W
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [BADDR_W-1:0] baddr_i,
  output logic [AW-1:0]      set_o,
  output logic [AW-1:0]      clr_o
);
  logic bpar;
  assign bpar = ^data_i;

  for (genvar k = 0; k < AW; k++) begin : g_bit
    if (k < BIDX_W) begin : g_pos
      localparam logic [31:0] MK = nand_ecc_pkg::idx_mask(k);
      assign set_o[k] = ^(data_i & MK[DATA_W-1:0]);
      assign clr_o[k] = ^(data_i & ~MK[DATA_W-1:0]);
    end else begin : g_byte
      assign set_o[k] = baddr_i[k-BIDX_W] & bpar;
      assign clr_o[k] = ~baddr_i[k-BIDX_W] & bpar;
    end
  end
endmodule

// File: rtl/nand_ecc_ctr.sv
// Byte position within the transfer and chunk selection.
module nand_ecc_ctr #(
  parameter int BADDR_W = 8,
  localparam int CNT_W  = BADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               adv_i,
  input  logic               wide_i,
  output logic [BADDR_W-1:0] baddr_o,
  output logic               bank_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    if (wide_i) cnt_nx = cnt_q + CNT_W'(1);
    else        cnt_nx = {1'b0, cnt_q[BADDR_W-1:0] + BADDR_W'(1)};
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i)  cnt_q <= '0;
    else if (adv_i)    cnt_q <= cnt_nx;
  end

  assign baddr_o = cnt_q[BADDR_W-1:0];
  assign bank_o  = wide_i & cnt_q[CNT_W-1];
endmodule

// File: rtl/nand_ecc_bank.sv
// One chunk's register pair, packed as {clear word, set word}.
module nand_ecc_bank #(
  parameter int AW = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            hit_i,
  input  logic [AW-1:0]   set_i,
  input  logic [AW-1:0]   clrw_i,
  output logic [2*AW-1:0] code_o
);
  logic [AW-1:0] set_q;
  logic [AW-1:0] clr_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      set_q <= '0;
      clr_q <= '0;
    end else if (hit_i) begin
      set_q <= set_q ^ set_i;
      clr_q <= clr_q ^ clrw_i;
    end
  end

  assign code_o = {clr_q, set_q};
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen #(
  parameter int DATA_W      = 8,
  parameter int CHUNK_BYTES = 256,
  localparam int BADDR_W    = $clog2(CHUNK_BYTES),
  localparam int AW         = BADDR_W + $clog2(DATA_W),
  localparam int CODE_W     = 2 * AW,
  localparam int NBANK      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              mode512_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [CODE_W-1:0] code0_o,
  output logic [CODE_W-1:0] code1_o
);
  logic               accept;
  logic [BADDR_W-1:0] baddr;
  logic               bank;
  logic [AW-1:0]      c_set;
  logic [AW-1:0]      c_clr;
  logic [CODE_W-1:0]  bank_code [NBANK];

  assign accept = valid_i & ~clr_i;

  nand_ecc_ctr #(.BADDR_W(BADDR_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr_i),
    .adv_i   (accept),
    .wide_i  (mode512_i),
    .baddr_o (baddr),
    .bank_o  (bank)
  );

  nand_ecc_contrib #(.DATA_W(DATA_W), .BADDR_W(BADDR_W)) u_contrib (
    .data_i  (byte_i),
    .baddr_i (baddr),
    .set_o   (c_set),
    .clr_o   (c_clr)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit;
    assign hit = accept & (bank == 1'(g));
    nand_ecc_bank #(.AW(AW)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (clr_i),
      .hit_i  (hit),
      .set_i  (c_set),
      .clrw_i (c_clr),
      .code_o (bank_code[g])
    );
  end

  assign code0_o = bank_code[0];
  assign code1_o = bank_code[1];
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
  parameter int DATA_W      = 8,
  parameter int CHUNK_BYTES = 256,
  localparam int AW         = $clog2(CHUNK_BYTES) + $clog2(DATA_W),
  localparam int CODE_W     = 2 * AW
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_i,
  input logic              mode512_i,
  input logic              valid_i,
  input logic [DATA_W-1:0] byte_i,
  input logic [CODE_W-1:0] code0_o,
  input logic [CODE_W-1:0] code1_o
);
  logic [CODE_W-1:0] dsum;
  assign dsum = code0_o ^ code1_o;

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (code0_o == '0) && (code1_o == '0));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!valid_i && !clr_i) |=> ($stable(code0_o) && $stable(code1_o)));

  p_narrow_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!mode512_i && !clr_i) |=> $stable(code1_o));

  p_one_chunk_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !clr_i) |=> ($stable(code0_o) || $stable(code1_o)));

  // R2: a byte-address bit is either set or clear, so the byte parity lands in exactly one word
  p_pair_parity_r2: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !clr_i) |=>
      ((dsum[AW-1] ^ $past(dsum[AW-1]) ^ dsum[CODE_W-1] ^ $past(dsum[CODE_W-1])) == ^$past(byte_i)));
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.DATA_W(DATA_W), .CHUNK_BYTES(CHUNK_BYTES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_i     (clr_i),
  .mode512_i (mode512_i),
  .valid_i   (valid_i),
  .byte_i    (byte_i),
  .code0_o   (code0_o),
  .code1_o   (code1_o)
);

// File: tb/nand_ecc_gen_test.sv
module nand_ecc_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_i = 1'b0;
  logic        mode512_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic [21:0] code0_o, code1_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] mem [512];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  nand_ecc_gen uut (
    .clk(clk), .rst(rst), .clr_i(clr_i), .mode512_i(mode512_i),
    .valid_i(valid_i), .byte_i(byte_i), .code0_o(code0_o), .code1_o(code1_o)
  );

  function automatic logic [21:0] ref_code(input int base);
    logic [10:0] lo = '0;
    logic [10:0] hi = '0;
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 8; j++)
        if (mem[base+i][j]) begin
          lo ^= 11'(i*8 + j);
          hi ^= ~11'(i*8 + j);
        end
    return {hi, lo};
  endfunction

  task automatic chk(input string tag, input logic [21:0] got, input logic [21:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    valid_i = 1'b1;
    byte_i  = d;
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
    byte_i  = 8'h5A;
  endtask

  task automatic do_clear();
    @(negedge clk);
    valid_i = 1'b0;
    clr_i   = 1'b1;
    @(negedge clk);
    clr_i   = 1'b0;
  endtask

  task automatic stream(input int base, input int n, input bit stall);
    for (int i = 0; i < n; i++) begin
      if (stall) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[0]) idle();
      end
      push(mem[base+i]);
    end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset code0", code0_o, 22'h0);
    chk("R1 reset code1", code1_o, 22'h0);

    // R4: erased chunk
    mode512_i = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    do_clear();
    stream(0, 256, 0);
    chk("R4 all-FF code0", code0_o, 22'h0);
    chk("R8 all-FF code1", code1_o, 22'h0);

    // R3: single-bit sweep over every byte position
    for (int b = 0; b < 256; b++) begin
      logic [10:0] a;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      mem[b] = 8'(1 << (b % 8));
      a = 11'(b*8 + (b % 8));
      do_clear();
      stream(0, 256, 0);
      chk("R3 single bit", code0_o, {~a, a});
    end

    // R2/R7: structured data in 512 mode
    mode512_i = 1'b1;
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    do_clear();
    stream(0, 256, 0);
    chk("R7 half code1 still zero", code1_o, 22'h0);
    chk("R2 first chunk", code0_o, ref_code(0));
    stream(256, 256, 0);
    chk("R7 upper chunk", code1_o, ref_code(256));
    chk("R7 lower chunk kept", code0_o, ref_code(0));
    push(8'h01);
    idle();
    chk("R7 wrap to chunk 0", code0_o, ref_code(0) ^ {11'h7FF, 11'h000});
    chk("R7 wrap leaves code1", code1_o, ref_code(256));

    // R5: same data with idle gaps carrying junk
    do_clear();
    stream(0, 512, 1);
    chk("R5 stalls code0", code0_o, ref_code(0));
    chk("R5 stalls code1", code1_o, ref_code(256));

    // R8: 256 mode, 512 bytes wrap into chunk 0
    mode512_i = 1'b0;
    do_clear();
    stream(0, 512, 0);
    chk("R8 wrap code0", code0_o, ref_code(0) ^ ref_code(256));
    chk("R8 code1 zero", code1_o, 22'h0);

    // R6: clear with a coincident byte
    @(negedge clk);
    clr_i = 1'b1; valid_i = 1'b1; byte_i = 8'hFF;
    @(negedge clk);
    clr_i = 1'b0; valid_i = 1'b0;
    chk("R6 clear code0", code0_o, 22'h0);
    chk("R6 clear code1", code1_o, 22'h0);
    push(8'h80);
    idle();
    chk("R6 dropped byte, position 0", code0_o, {~11'd7, 11'd7});

    // R9: latency of one edge
    do_clear();
    @(negedge clk);
    valid_i = 1'b1; byte_i = 8'h01;
    #1;
    chk("R9 before edge", code0_o, 22'h0);
    @(negedge clk);
    valid_i = 1'b0;
    chk("R9 after edge", code0_o, {11'h7FF, 11'h000});

    // R1: reset mid-run
    push(8'h3C);
    @(negedge clk);
    valid_i = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid-run reset", code0_o, 22'h0);
    push(8'h02);
    idle();
    chk("R1 position 0 after reset", code0_o, {~11'd1, 11'd1});

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule